// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a memory-mapped real-time clock core. A 32-bit seconds counter is advanced by a prescaler that divides a 32.768 kHz clock enable down to one increment per second. Software loads the counter, reads the live count and the prescaler phase, and programs an alarm compare value. A control register sets the clock's behaviour. Writes to the control register and to the battery-charger register are bit-masked: the upper half of the written word selects which bits of the lower half take effect.

The alarm is handled by a four-state sequencer. The states are ALM_IDLE (not armed), ALM_ARMED (comparing), ALM_FIRE (one-cycle event) and ALM_DONE (fired, waiting to be re-armed). The transitions are as follows:

- IDLE→ARMED happens when the alarm is enabled and the compare value is nonzero. On this transition the sequencer records whether the count is already past the compare value.
- ARMED→FIRE happens on an equal count. With overdue mode on and the count already past the compare value, it happens instead on the next seconds increment.
- ARMED→IDLE happens when the alarm is disabled or the compare value is zero.
- FIRE→DONE always follows one cycle after FIRE.
- Any state goes to IDLE on a re-arm. A re-arm is a write to the alarm register, or a control write whose mask covers the enable or overdue bit.

The alarm event raises an interrupt pulse. It also raises a wake request towards a power controller when routing is enabled.

There are two resets. A power-on reset clears everything. A system reset clears the counter, prescaler, alarm, user data, control register and sequencer, but only while the protect bit is 0. The charger controls and trim value are cleared only by the power-on reset. The charger bits are stored and driven out as static controls.

Top module: `rtc_sec_core`

## Requirements
- R1: After power-on reset, every register reads 0: control, count, alarm, user data, reset record, battery and trim. The outputs alarm_irq, wake_req, chg_rsel, chg_diode_off and chg_en are all 0.
- R2: A write to control (0x40) or battery (0x5C) changes bit n of the lower half only when bit n+16 of the written word is 1. Bits whose mask bit is 0 keep their value.
- R3: With tick_en high on every cycle, the count rises by exactly one every PRESC_DIV cycles. With tick_en low, the count does not advance. From 0xFFFFFFFF the count wraps to 0.
- R4: A write to 0x4C replaces the count and clears the prescaler. Offset 0x44 reads the live count. Offset 0x48 reads the prescaler phase, which is always below PRESC_DIV.
- R5: While control bit 5 (freeze) is 1, the count and prescaler hold. While control bit 3 is 1, the prescaler is held at zero, so the count does not advance.
- R6: Offset 0x50 reads back the last alarm value written. With control bit 0 set and a nonzero alarm value, an equal count raises alarm_irq.
- R7: An alarm value of 0 never fires, even when the count is 0. With control bit 0 clear, no alarm fires.
- R8: If control bit 2 (overdue) is 1 and the count is already above the alarm value when the alarm is armed, the alarm fires on the next seconds increment. With bit 2 at 0, such an alarm does not fire.
- R9: wake_req pulses together with alarm_irq only when control bit 1 is 1.
- R10: A system reset with control bit 4 at 1 leaves the count, alarm, user data and control unchanged. With bit 4 at 0, it clears them. Battery and trim are unaffected by a system reset in either case.
- R11: Offset 0x54 stores and returns any 32-bit value.
- R12: Battery bits 3:2 drive chg_rsel (0=2 kΩ, 1=250 Ω, 2=50 Ω, 3=0 Ω). Bit 1 drives chg_diode_off. Bit 0 drives chg_en.
- R13: In the reset record (0x58), bit 0 is set by a system reset blocked by protection, and bit 1 is set by a system reset that cleared state. Any write to 0x58 clears both bits.
- R14: Each arming gives at most one alarm event. alarm_irq is high for exactly one cycle, so each event is a single low-to-high edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low, gated by the protect bit |
| tick_en | input | 1 | 32.768 kHz clock enable, one cycle wide |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data (upper half is the mask for masked registers) |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| alarm_irq | output | 1 | One-cycle alarm pulse |
| wake_req | output | 1 | One-cycle wake request to the power controller |
| chg_rsel | output | 2 | Charge resistor select |
| chg_diode_off | output | 1 | 1 = series diode bypassed |
| chg_en | output | 1 | Charger enable |

## Verification
The embedded assertions check four properties on every cycle:

- The count moves by at most one per cycle outside loads and resets.
- A frozen counter holds, and a load lands in the following cycle.
- Masked writes disturb no unmasked bit, and protected system resets leave user data and the alarm alone.
- Every alarm pulse lasts one cycle, comes from a nonzero enabled compare value, and carries wake only when routing is on.

Only the bench scenarios can show the following:

- Exact arithmetic of the count over many prescaler periods, and the wrap.
- Whether an alarm fires at the right count or on the next increment in overdue mode.
- That zero and disabled alarms stay silent over long windows.
- How the reset record, battery and trim registers behave across both kinds of reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int CTL_W  = 6;
    localparam int BAT_W  = 4;
    localparam int TRIM_W = 16;
    localparam int REC_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_NOW    = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_PHASE  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_LOAD   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_USER   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_RSTREC = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_BATT   = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_TRIM   = 8'h60;

    // control bit positions (software decodes these)
    localparam int CB_ALM_EN  = 0;
    localparam int CB_WAKE    = 1;
    localparam int CB_OVD     = 2;
    localparam int CB_PRE_CLR = 3;
    localparam int CB_PROT    = 4;
    localparam int CB_FRZ     = 5;

    typedef struct packed {
        logic frz;
        logic prot;
        logic pre_clr;
        logic ovd;
        logic wake;
        logic alm_en;
    } ctl_t;

    typedef enum logic [1:0] {
        ALM_IDLE,
        ALM_ARMED,
        ALM_FIRE,
        ALM_DONE
    } alm_state_e;

    function automatic logic [15:0] masked_update(input logic [15:0] cur,
                                                  input logic [31:0] wd);
        return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int DIV   = 32768,
    parameter int PW    = $clog2(DIV)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_clr,
    input  logic             load_stb,
    input  logic [SEC_W-1:0] load_val,
    input  logic             freeze,
    input  logic             pre_clr,
    input  logic             tick_en,
    output logic [SEC_W-1:0] cnt,
    output logic [PW-1:0]    phase,
    output logic             sec_tick
);

    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [SEC_W-1:0] cnt_q;
    logic [PW-1:0]    pre_q;
    logic             adv;

    always_comb begin
        adv      = !soft_clr && !load_stb && !freeze && !pre_clr && tick_en;
        sec_tick = adv && (pre_q == LAST);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (soft_clr) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load_stb) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (freeze) begin
            cnt_q <= cnt_q;
            pre_q <= pre_q;
        end else if (pre_clr) begin
            pre_q <= '0;
        end else if (tick_en) begin
            if (pre_q == LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q + SEC_W'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    assign cnt   = cnt_q;
    assign phase = pre_q;

    // R5: frozen counter and prescaler hold
    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        (freeze && !load_stb && !soft_clr) |=> (cnt_q == $past(cnt_q) && pre_q == $past(pre_q)));

    // R3: count never moves by more than one outside loads and resets
    p_step_one_r3: assert property (@(posedge clk) disable iff (!por_n)
        (!load_stb && !soft_clr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + SEC_W'(1)));

    // R4: a load lands next cycle with the prescaler cleared
    p_load_lands_r4: assert property (@(posedge clk) disable iff (!por_n)
        (load_stb && !soft_clr) |=> (cnt_q == $past(load_val) && pre_q == '0));

endmodule

// File: rtl/rtc_alarm_seq.sv
module rtc_alarm_seq
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_clr,
    input  logic             rearm,
    input  logic             alm_en,
    input  logic             ovd_en,
    input  logic             wake_en,
    input  logic [SEC_W-1:0] cnt,
    input  logic [SEC_W-1:0] alarm_val,
    input  logic             sec_tick,
    output logic             irq,
    output logic             wake
);

    alm_state_e state_q, state_d;
    logic       late_q, late_d;
    logic       valid;

    always_comb begin
        valid   = alm_en && (alarm_val != '0);
        state_d = state_q;
        late_d  = late_q;
        if (rearm) begin
            state_d = ALM_IDLE;
        end else begin
            unique case (state_q)
                ALM_IDLE: begin
                    if (valid) begin
                        state_d = ALM_ARMED;
                        late_d  = (cnt > alarm_val);
                    end
                end
                ALM_ARMED: begin
                    if (!valid)                              state_d = ALM_IDLE;
                    else if (cnt == alarm_val)               state_d = ALM_FIRE;
                    else if (late_q && ovd_en && sec_tick)   state_d = ALM_FIRE;
                end
                ALM_FIRE: state_d = ALM_DONE;
                ALM_DONE: begin
                    if (!valid) state_d = ALM_IDLE;
                end
                default: state_d = ALM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ALM_IDLE;
            late_q  <= 1'b0;
        end else if (soft_clr) begin
            state_q <= ALM_IDLE;
            late_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            late_q  <= late_d;
        end
    end

    always_comb begin
        irq  = (state_q == ALM_FIRE);
        wake = (state_q == ALM_FIRE) && wake_en;
    end

    // R14: each event is a one-cycle pulse
    p_single_pulse_r14: assert property (@(posedge clk) disable iff (!por_n)
        irq |=> !irq);

    // R7: an event only follows an enabled, nonzero compare value
    p_zero_silent_r7: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> ($past(alarm_val) != '0 && $past(alm_en)));

    // R9: wake only accompanies an event with routing on
    p_wake_gate_r9: assert property (@(posedge clk) disable iff (!por_n)
        wake |-> (irq && wake_en));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int PW    = 15
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_clr,
    input  logic              sys_blocked,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SEC_W-1:0]  cnt,
    input  logic [PW-1:0]     phase,
    output ctl_t              ctl,
    output logic [SEC_W-1:0]  alarm_val,
    output logic [DATA_W-1:0] user_val,
    output logic [BAT_W-1:0]  batt,
    output logic              load_stb,
    output logic [SEC_W-1:0]  load_val,
    output logic              rearm,
    output logic [DATA_W-1:0] rdata
);

    logic [CTL_W-1:0]  ctl_q;
    logic [SEC_W-1:0]  alarm_q;
    logic [DATA_W-1:0] user_q;
    logic [BAT_W-1:0]  batt_q;
    logic [TRIM_W-1:0] trim_q;
    logic [REC_W-1:0]  rec_q;
    logic [15:0]       ctl_nx, batt_nx;
    logic              wr_any, wr_ctrl, wr_alarm, wr_user, wr_batt, wr_trim, wr_rec;

    always_comb begin
        wr_any   = bus_sel && bus_wr;
        wr_ctrl  = wr_any && (bus_addr == OFS_CTRL);
        wr_alarm = wr_any && (bus_addr == OFS_ALARM);
        wr_user  = wr_any && (bus_addr == OFS_USER);
        wr_batt  = wr_any && (bus_addr == OFS_BATT);
        wr_trim  = wr_any && (bus_addr == OFS_TRIM);
        wr_rec   = wr_any && (bus_addr == OFS_RSTREC);
        load_stb = wr_any && (bus_addr == OFS_LOAD);
        load_val = bus_wdata[SEC_W-1:0];
        rearm    = wr_alarm ||
                   (wr_ctrl && (bus_wdata[16+CB_ALM_EN] || bus_wdata[16+CB_OVD]));
        ctl_nx   = masked_update({{(16-CTL_W){1'b0}}, ctl_q}, bus_wdata);
        batt_nx  = masked_update({{(16-BAT_W){1'b0}}, batt_q}, bus_wdata);
    end

    // state guarded by the protect bit
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q   <= '0;
            alarm_q <= '0;
            user_q  <= '0;
        end else if (soft_clr) begin
            ctl_q   <= '0;
            alarm_q <= '0;
            user_q  <= '0;
        end else begin
            if (wr_ctrl)  ctl_q   <= ctl_nx[CTL_W-1:0];
            if (wr_alarm) alarm_q <= bus_wdata[SEC_W-1:0];
            if (wr_user)  user_q  <= bus_wdata;
        end
    end

    // state cleared by power-on reset only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            batt_q <= '0;
            trim_q <= '0;
            rec_q  <= '0;
        end else begin
            if (wr_batt) batt_q <= batt_nx[BAT_W-1:0];
            if (wr_trim) trim_q <= bus_wdata[TRIM_W-1:0];
            if (wr_rec) begin
                rec_q <= '0;
            end else begin
                if (sys_blocked) rec_q[0] <= 1'b1;
                if (soft_clr)    rec_q[1] <= 1'b1;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:   rdata = DATA_W'(ctl_q);
            OFS_NOW:    rdata = DATA_W'(cnt);
            OFS_PHASE:  rdata = DATA_W'(phase);
            OFS_ALARM:  rdata = DATA_W'(alarm_q);
            OFS_USER:   rdata = user_q;
            OFS_RSTREC: rdata = DATA_W'(rec_q);
            OFS_BATT:   rdata = DATA_W'(batt_q);
            OFS_TRIM:   rdata = DATA_W'(trim_q);
            default:    rdata = '0;
        endcase
    end

    assign ctl       = ctl_t'(ctl_q);
    assign alarm_val = alarm_q;
    assign user_val  = user_q;
    assign batt      = batt_q;

    // R2: unmasked control bits are undisturbed by a control write
    p_ctl_mask_r2: assert property (@(posedge clk) disable iff (!por_n)
        (wr_ctrl && !soft_clr) |=> (((ctl_q ^ $past(ctl_q)) & ~$past(bus_wdata[16 +: CTL_W])) == '0));

    // R2: unmasked battery bits are undisturbed by a battery write
    p_batt_mask_r2: assert property (@(posedge clk) disable iff (!por_n)
        wr_batt |=> (((batt_q ^ $past(batt_q)) & ~$past(bus_wdata[16 +: BAT_W])) == '0));

endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_pkg::*;
#(
    parameter int SEC_W     = 32,
    parameter int PRESC_DIV = 32768
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        tick_en,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        alarm_irq,
    output logic        wake_req,
    output logic [1:0]  chg_rsel,
    output logic        chg_diode_off,
    output logic        chg_en
);

    localparam int PW = $clog2(PRESC_DIV);

    ctl_t             ctl;
    logic [SEC_W-1:0] cnt, alarm_val, load_val;
    logic [PW-1:0]    phase;
    logic [31:0]      user_val;
    logic [BAT_W-1:0] batt;
    logic             load_stb, rearm, sec_tick, soft_clr, sys_blocked;

    always_comb begin
        soft_clr    = !sys_rst_n && !ctl.prot;
        sys_blocked = !sys_rst_n && ctl.prot;
    end

    rtc_regfile #(.SEC_W(SEC_W), .PW(PW)) u_regs (
        .clk(clk), .por_n(por_n), .soft_clr(soft_clr), .sys_blocked(sys_blocked),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cnt(cnt), .phase(phase), .ctl(ctl), .alarm_val(alarm_val), .user_val(user_val),
        .batt(batt), .load_stb(load_stb), .load_val(load_val), .rearm(rearm),
        .rdata(bus_rdata)
    );

    rtc_timebase #(.SEC_W(SEC_W), .DIV(PRESC_DIV), .PW(PW)) u_time (
        .clk(clk), .por_n(por_n), .soft_clr(soft_clr), .load_stb(load_stb),
        .load_val(load_val), .freeze(ctl.frz), .pre_clr(ctl.pre_clr),
        .tick_en(tick_en), .cnt(cnt), .phase(phase), .sec_tick(sec_tick)
    );

    rtc_alarm_seq #(.SEC_W(SEC_W)) u_alarm (
        .clk(clk), .por_n(por_n), .soft_clr(soft_clr), .rearm(rearm),
        .alm_en(ctl.alm_en), .ovd_en(ctl.ovd), .wake_en(ctl.wake),
        .cnt(cnt), .alarm_val(alarm_val), .sec_tick(sec_tick),
        .irq(alarm_irq), .wake(wake_req)
    );

    always_comb begin
        chg_rsel      = batt[3:2];
        chg_diode_off = batt[1];
        chg_en        = batt[0];
    end

    // R10: a protected system reset leaves user data and alarm intact
    p_protect_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && ctl.prot && !(bus_sel && bus_wr))
            |=> (user_val == $past(user_val) && alarm_val == $past(alarm_val)));

endmodule

// File: tb/sim_rtc_sec_core.sv
module sim_rtc_sec_core;
    import rtc_pkg::*;

    localparam int DIV = 8;

    logic        clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b1, tick_en = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake, diode_off, chg_en;
    logic [1:0]  rsel;

    int checks = 0, errors = 0, irq_seen = 0;
    bit exp_q[$];
    bit exp_w, prev_irq = 1'b0;

    always #4 clk = ~clk;

    rtc_sec_core #(.SEC_W(32), .PRESC_DIV(DIV)) u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(irq), .wake_req(wake),
        .chg_rsel(rsel), .chg_diode_off(diode_off), .chg_en(chg_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (irq) begin got = 1'b1; break; end
        end
    endtask

    task automatic sys_pulse();
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
    endtask

    // scoreboard monitor: every alarm event is matched to an expected item
    always @(negedge clk) begin
        if (por_n) begin
            if (irq && prev_irq) begin
                checks++; errors++;
                $display("FAIL R14: alarm_irq high two cycles, actual 1 expected 0");
            end
            if (irq) begin
                irq_seen++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7: unexpected alarm event, actual 1 expected 0");
                end else begin
                    exp_w = exp_q.pop_front();
                    if (wake !== exp_w) begin
                        errors++;
                        $display("FAIL R9: wake_req actual %0b expected %0b", wake, exp_w);
                    end
                end
            end
            prev_irq = irq;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, c1;
        bit got;
        int seen0;

        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1: reset state
        rd(OFS_CTRL, d);   check("R1 ctrl", d, 0);
        rd(OFS_NOW, d);    check("R1 count", d, 0);
        rd(OFS_ALARM, d);  check("R1 alarm", d, 0);
        rd(OFS_USER, d);   check("R1 user", d, 0);
        rd(OFS_BATT, d);   check("R1 batt", d, 0);
        rd(OFS_TRIM, d);   check("R1 trim", d, 0);
        rd(OFS_RSTREC, d); check("R1 record", d, 0);
        check("R1 outputs", {26'd0, irq, wake, rsel, diode_off, chg_en}, 0);

        // R3/R4: load and count
        tick_en = 1'b1;
        wr(OFS_LOAD, 32'd100);
        repeat (40) @(posedge clk);
        rd(OFS_NOW, d); check("R3 five seconds after load", d, 105);
        tick_en = 1'b0;
        rd(OFS_NOW, c1);
        repeat (40) @(posedge clk);
        rd(OFS_NOW, d); check("R3 no enable no advance", d, c1);
        rd(OFS_PHASE, d); check("R4 phase below divider", {31'd0, d < DIV}, 1);
        tick_en = 1'b1;
        wr(OFS_LOAD, 32'hFFFF_FFFF);
        repeat (8) @(posedge clk);
        rd(OFS_NOW, d); check("R3 wrap to zero", d, 0);

        // R5: freeze and prescaler clear
        wr(OFS_CTRL, 32'h0020_0020);
        rd(OFS_NOW, c1);
        repeat (40) @(posedge clk);
        rd(OFS_NOW, d); check("R5 freeze holds", d, c1);
        wr(OFS_CTRL, 32'h0028_0008);
        rd(OFS_NOW, c1);
        repeat (40) @(posedge clk);
        rd(OFS_NOW, d); check("R5 prescaler clear holds", d, c1);
        wr(OFS_CTRL, 32'h0008_0000);

        // R2: masked control writes
        rd(OFS_CTRL, d); check("R2 ctrl unmasked start", d, 0);
        wr(OFS_CTRL, 32'h0000_003F);
        rd(OFS_CTRL, d); check("R2 zero mask no change", d, 0);
        wr(OFS_CTRL, 32'h0001_0001);
        rd(OFS_CTRL, d); check("R2 bit0 only", d, 32'h1);
        wr(OFS_CTRL, 32'h0004_0007);
        rd(OFS_CTRL, d); check("R2 bit2 added, bit1 masked", d, 32'h5);
        wr(OFS_CTRL, 32'h0005_0000);
        rd(OFS_CTRL, d); check("R2 cleared", d, 0);

        // R6/R9: equality alarm with wake routing
        wr(OFS_LOAD, 32'd200);
        wr(OFS_ALARM, 32'd203);
        rd(OFS_ALARM, d); check("R6 alarm readback", d, 203);
        exp_q.push_back(1'b1);
        wr(OFS_CTRL, 32'h0003_0003);
        wait_irq(100, got);
        check("R6 alarm fired", {31'd0, got}, 1);
        rd(OFS_NOW, d); check("R6 count at alarm", d, 203);

        // R7: zero alarm and disabled alarm stay silent
        seen0 = irq_seen;
        wr(OFS_ALARM, 32'd0);
        wr(OFS_LOAD, 32'd0);
        repeat (60) @(posedge clk);
        check("R7 zero alarm silent", irq_seen, seen0);
        wr(OFS_CTRL, 32'h0001_0000);
        wr(OFS_LOAD, 32'd48);
        wr(OFS_ALARM, 32'd50);
        repeat (40) @(posedge clk);
        check("R7 disabled alarm silent", irq_seen, seen0);

        // R8: overdue alarm
        wr(OFS_LOAD, 32'd500);
        wr(OFS_ALARM, 32'd400);
        wr(OFS_CTRL, 32'h0001_0001);
        repeat (40) @(posedge clk);
        check("R8 late alarm silent without overdue", irq_seen, seen0);
        exp_q.push_back(1'b1);
        wr(OFS_CTRL, 32'h0004_0004);
        wait_irq(40, got);
        check("R8 overdue fired", {31'd0, got}, 1);
        rd(OFS_NOW, d); check("R8 count past alarm", {31'd0, d > 400}, 1);

        // R9: no wake when routing off
        wr(OFS_CTRL, 32'h0006_0000);
        wr(OFS_LOAD, 32'd590);
        exp_q.push_back(1'b0);
        wr(OFS_ALARM, 32'd594);
        wait_irq(100, got);
        check("R9 alarm without wake fired", {31'd0, got}, 1);

        // R11/R12: user data, battery, trim
        wr(OFS_USER, 32'hCAFE_F00D);
        rd(OFS_USER, d); check("R11 user readback", d, 32'hCAFE_F00D);
        wr(OFS_BATT, 32'h000F_0009);
        check("R12 rsel=2 diode on en", {28'd0, rsel, diode_off, chg_en}, 32'h9);
        wr(OFS_BATT, 32'h0002_000F);
        check("R12 masked diode off", {28'd0, rsel, diode_off, chg_en}, 32'hB);
        wr(OFS_TRIM, 32'h0000_1234);

        // R10/R13: protected system reset
        wr(OFS_CTRL, 32'h0010_0010);
        sys_pulse();
        rd(OFS_USER, d);  check("R10 protected user", d, 32'hCAFE_F00D);
        rd(OFS_CTRL, d);  check("R10 protected ctrl", d, 32'h11);
        rd(OFS_ALARM, d); check("R10 protected alarm", d, 594);
        rd(OFS_NOW, d);   check("R10 protected count", {31'd0, d >= 594}, 1);

        // R10/R13: unprotected system reset
        wr(OFS_CTRL, 32'h0010_0000);
        sys_pulse();
        rd(OFS_USER, d);  check("R10 cleared user", d, 0);
        rd(OFS_CTRL, d);  check("R10 cleared ctrl", d, 0);
        rd(OFS_ALARM, d); check("R10 cleared alarm", d, 0);
        rd(OFS_NOW, d);   check("R10 cleared count", d, 0);
        rd(OFS_BATT, d);  check("R10 battery kept", d, 32'hB);
        rd(OFS_TRIM, d);  check("R10 trim kept", d, 32'h1234);
        rd(OFS_RSTREC, d); check("R13 record both", d, 32'h3);
        wr(OFS_RSTREC, 32'h0);
        rd(OFS_RSTREC, d); check("R13 record cleared", d, 0);

        repeat (5) @(posedge clk);
        check("R6 all expected alarms seen", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule